// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulate Unit

This block is a vector datapath stage that takes an addend vector and two source vectors and, for every 32-bit lane, adds to the addend the sum of four byte-by-byte products. The products are taken from the four byte positions that fall inside that lane. The operation runs in a 128-bit form with four lanes or in a 64-bit form with two lanes. Bytes are read either all as two's complement or all as unsigned, chosen by one select. Forms that mix signed and unsigned operands are not offered.

In the indexed form, one 32-bit group of four bytes from the second source is picked by a lane index. That same group is then used as the second operand for every lane. The range of the index depends only on the declared width of the second source. An index outside that range is reported on an error output, and the stored result is left untouched.

Operands are taken on a valid/ready handshake and the result is registered. The result appears one cycle after acceptance with a result-valid strobe. It is held while the consumer withholds ready.

Top module: `bdot_unit`

## Requirements
- R1: Lane k occupies bits [32k+31:32k] and byte j of lane k occupies bits [32k+8j+7:32k+8j]. In the non-indexed form, result lane k equals addend lane k plus the sum over j = 0..3 of source-A byte j of lane k times source-B byte j of lane k.
- R2: With `wide_i`=1 all four lanes are produced. With `wide_i`=0 only lanes 0 and 1 are produced, from bytes 0..7, and result bits [127:64] are zero.
- R3: With `signed_i`=1 every byte is two's complement and each product is sign-extended into the lane sum. With `signed_i`=0 every byte is unsigned and each product is zero-extended.
- R4: With `idx_mode_i`=1 every lane uses its own source-A bytes together with source-B bits [32*idx+31:32*idx] as its four B bytes.
- R5: The permitted index is 0..1 when `b_wide_i`=0 and 0..3 when `b_wide_i`=1. This holds whatever the value of `wide_i`.
- R6: An accepted indexed operation whose index exceeds the permitted range returns `out_valid_o`=1 with `err_o`=1 and leaves `result_o` at its previous value. Outside the indexed form the index is ignored and raises no error.
- R7: An operation is accepted when `in_valid_i` and `in_ready_o` are both 1, and `out_valid_o` is 1 in the next cycle. While `out_valid_o`=1 and `out_ready_i`=0, `in_ready_o` is 0 and `result_o` and `err_o` hold. A result may drain in the same cycle that a new operation is accepted.
- R8: After reset, `out_valid_o`=0, `err_o`=0 and `result_o`=0.
- R9: The final lane addition wraps modulo 2^32, with no saturation and no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken this cycle |
| wide_i | input | 1 | 1: four-lane form, 0: two-lane form |
| b_wide_i | input | 1 | Second source width for the index range: 1 = 128-bit, 0 = 64-bit |
| idx_mode_i | input | 1 | 1: indexed broadcast of one B group |
| signed_i | input | 1 | 1: signed bytes, 0: unsigned bytes |
| idx_i | input | 2 | Index of the 32-bit B group |
| acc_i | input | 128 | Addend vector |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| err_o | output | 1 | Index out of range for the presented result |
| result_o | output | 128 | Accumulated result vector |

## Verification
Two things can happen in the same cycle: a held result drains, and a new operation is accepted. The bench stalls the consumer so that one result is held while a different operation waits at the input. It then raises `out_ready_i` with the waiting operation still offered. It judges that the stalled result never changed, that the waiting operation was not taken early, and that the next cycle shows the new result with valid still high. An out-of-range index following a good result is also checked: the error must appear in the same cycle as the unchanged result.

// File: rtl/bdot_pkg.sv
package bdot_pkg;
  localparam int DOT_LANES  = 4;
  localparam int DOT_LANE_W = 32;
  localparam int DOT_ELEM_W = 8;

  typedef enum logic {
    ELEM_UNSIGNED = 1'b0,
    ELEM_SIGNED   = 1'b1
  } elem_sign_e;
endpackage

// File: rtl/bdot_bsel.sv
module bdot_bsel #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                      idx_mode,
  input  logic [IDX_W-1:0]          idx,
  input  logic [LANES*LANE_W-1:0]   src_b,
  output logic [LANES*LANE_W-1:0]   b_sel
);
  logic [LANE_W-1:0] picked;

  assign picked = src_b[idx*LANE_W +: LANE_W];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign b_sel[k*LANE_W +: LANE_W] = idx_mode ? picked : src_b[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bdot_lane.sv
module bdot_lane
  import bdot_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int ELEM_W = 8
) (
  input  elem_sign_e          sign_mode,
  input  logic [LANE_W-1:0]   acc,
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b,
  output logic [LANE_W-1:0]   sum
);
  localparam int ELEMS  = LANE_W / ELEM_W;
  localparam int PROD_W = 2 * ELEM_W;
  localparam int SUM_W  = PROD_W + $clog2(ELEMS);

  logic              sgn;
  logic [PROD_W-1:0] prod [ELEMS];
  logic [SUM_W-1:0]  total;
  logic [LANE_W-1:0] total_ext;

  assign sgn = (sign_mode == ELEM_SIGNED);

  for (genvar j = 0; j < ELEMS; j++) begin : g_mul
    logic [ELEM_W-1:0]        ab;
    logic [ELEM_W-1:0]        bb;
    logic signed [PROD_W-1:0] wa;
    logic signed [PROD_W-1:0] wb;
    assign ab = a[j*ELEM_W +: ELEM_W];
    assign bb = b[j*ELEM_W +: ELEM_W];
    assign wa = {{(PROD_W-ELEM_W){sgn & ab[ELEM_W-1]}}, ab};
    assign wb = {{(PROD_W-ELEM_W){sgn & bb[ELEM_W-1]}}, bb};
    assign prod[j] = wa * wb;
  end

  always_comb begin
    total = '0;
    for (int j = 0; j < ELEMS; j++) begin
      total = total + {{(SUM_W-PROD_W){sgn & prod[j][PROD_W-1]}}, prod[j]};
    end
  end

  assign total_ext = {{(LANE_W-SUM_W){sgn & total[SUM_W-1]}}, total};
  assign sum       = acc + total_ext;
endmodule

// File: rtl/bdot_unit.sv
module bdot_unit
  import bdot_pkg::*;
#(
  parameter int LANES  = DOT_LANES,
  parameter int LANE_W = DOT_LANE_W,
  parameter int ELEM_W = DOT_ELEM_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic                        wide_i,
  input  logic                        b_wide_i,
  input  logic                        idx_mode_i,
  input  logic                        signed_i,
  input  logic [$clog2(LANES)-1:0]    idx_i,
  input  logic [LANES*LANE_W-1:0]     acc_i,
  input  logic [LANES*LANE_W-1:0]     src_a_i,
  input  logic [LANES*LANE_W-1:0]     src_b_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic                        err_o,
  output logic [LANES*LANE_W-1:0]     result_o
);
  localparam int IDX_W = $clog2(LANES);
  localparam int VEC_W = LANES * LANE_W;
  localparam int HALF  = LANES / 2;
  localparam logic [IDX_W-1:0] NARROW_MAX = IDX_W'(HALF - 1);

  logic [VEC_W-1:0] b_sel;
  logic [VEC_W-1:0] lane_res;
  logic [VEC_W-1:0] masked;
  elem_sign_e       sign_mode;

  logic             accept;
  logic             idx_bad;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             res_en;
  logic [VEC_W-1:0] res_q;

  assign sign_mode = signed_i ? ELEM_SIGNED : ELEM_UNSIGNED;

  bdot_bsel #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_bsel (
    .idx_mode (idx_mode_i),
    .idx      (idx_i),
    .src_b    (src_b_i),
    .b_sel    (b_sel)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bdot_lane #(.LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_lane (
      .sign_mode (sign_mode),
      .acc       (acc_i[k*LANE_W +: LANE_W]),
      .a         (src_a_i[k*LANE_W +: LANE_W]),
      .b         (b_sel[k*LANE_W +: LANE_W]),
      .sum       (lane_res[k*LANE_W +: LANE_W])
    );
    if (k >= HALF) begin : g_upper
      assign masked[k*LANE_W +: LANE_W] = wide_i ? lane_res[k*LANE_W +: LANE_W] : '0;
    end else begin : g_lower
      assign masked[k*LANE_W +: LANE_W] = lane_res[k*LANE_W +: LANE_W];
    end
  end

  // handshake and next-state
  always_comb begin
    in_ready_o = !valid_q || out_ready_i;
    accept     = in_valid_i && in_ready_o;
    idx_bad    = idx_mode_i && !b_wide_i && (idx_i > NARROW_MAX);
    res_en     = accept && !idx_bad;
    if (accept) begin
      valid_d = 1'b1;
      err_d   = idx_bad;
    end else if (out_ready_i) begin
      valid_d = 1'b0;
      err_d   = 1'b0;
    end else begin
      valid_d = valid_q;
      err_d   = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= masked;
    end
  end

  assign out_valid_o = valid_q;
  assign err_o       = err_q;
  assign result_o    = res_q;

  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o) && $stable(err_o)));

  assert_bad_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && idx_mode_i && !b_wide_i && (idx_i > NARROW_MAX))
      |=> (err_o && out_valid_o && $stable(result_o)));

  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !wide_i && !idx_mode_i) |=> (result_o[VEC_W-1:VEC_W/2] == '0));
endmodule

// File: tb/bdot_unit_test.sv
module bdot_unit_test;
  logic         clk;
  logic         rst_n;
  logic         in_valid_i;
  logic         in_ready_o;
  logic         wide_i;
  logic         b_wide_i;
  logic         idx_mode_i;
  logic         signed_i;
  logic [1:0]   idx_i;
  logic [127:0] acc_i;
  logic [127:0] src_a_i;
  logic [127:0] src_b_i;
  logic         out_valid_o;
  logic         out_ready_i;
  logic         err_o;
  logic [127:0] result_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  bdot_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .wide_i(wide_i), .b_wide_i(b_wide_i), .idx_mode_i(idx_mode_i), .signed_i(signed_i),
    .idx_i(idx_i), .acc_i(acc_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .err_o(err_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [127:0] ZV   = 128'h0;
  localparam logic [127:0] ONES = 128'h01010101_01010101_01010101_01010101;
  localparam logic [127:0] BINC = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
  localparam logic [127:0] ALLF = 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF;
  localparam logic [127:0] A80  = 128'h80808080_80808080_80808080_80808080;
  localparam logic [127:0] AMIX = 128'hDEADBEEF_01234567_89ABCDEF_7F80FF01;
  localparam logic [127:0] BMIX = 128'h13579BDF_FEDCBA98_0F1E2D3C_80017FFE;
  localparam logic [127:0] ACCS = 128'h00000010_FFFFFFF0_80000000_7FFFFFFF;
  localparam logic [127:0] AMAX = 128'h7FFFFFFF_7FFFFFFF_7FFFFFFF_7FFFFFFF;

  // control bits: [5]=wide [4]=b_wide [3]=indexed [2]=signed [1:0]=index
  localparam int NVEC = 10;
  localparam logic [389:0] VEC [NVEC] = '{
    {6'b100000, ZV,   ONES, BINC},
    {6'b100100, ACCS, ALLF, A80 },
    {6'b000100, ACCS, AMIX, BMIX},
    {6'b111011, ACCS, AMIX, BMIX},
    {6'b101101, ZV,   AMIX, BMIX},
    {6'b100000, ALLF, ALLF, ALLF},
    {6'b100100, AMAX, A80,  A80 },
    {6'b011010, ACCS, AMIX, BINC},
    {6'b100111, ACCS, AMIX, BMIX},
    {6'b011111, ZV,   BINC, BMIX}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";
      1: return "R3";
      2: return "R2";
      3, 4: return "R4";
      5, 6: return "R9";
      7, 9: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [127:0] model(logic wide, logic idxm, logic sgn, logic [1:0] idx,
                                         logic [127:0] acc, logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      int s;
      int bk;
      if (!wide && k >= 2) continue;
      s  = int'(acc[32*k +: 32]);
      bk = idxm ? int'(idx) : k;
      for (int j = 0; j < 4; j++) begin
        logic [7:0] ab;
        logic [7:0] bb;
        int pa;
        int pb;
        ab = a[32*k + 8*j +: 8];
        bb = b[32*bk + 8*j +: 8];
        pa = sgn ? int'($signed(ab)) : int'(ab);
        pb = sgn ? int'($signed(bb)) : int'(bb);
        s  = s + pa * pb;
      end
      r[32*k +: 32] = s;
    end
    return r;
  endfunction

  task automatic check128(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check1(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] ctl, logic [127:0] acc, logic [127:0] a, logic [127:0] b);
    wide_i     = ctl[5];
    b_wide_i   = ctl[4];
    idx_mode_i = ctl[3];
    signed_i   = ctl[2];
    idx_i      = ctl[1:0];
    acc_i      = acc;
    src_a_i    = a;
    src_b_i    = b;
  endtask

  // offer one operation at a negedge, return at the next negedge with inputs withdrawn
  task automatic issue(logic [5:0] ctl, logic [127:0] acc, logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    drive(ctl, acc, a, b);
    in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] last;
    logic [127:0] p_res;
    logic [127:0] q_res;
    rst_n       = 1'b0;
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    drive(6'b0, ZV, ZV, ZV);
    repeat (3) @(negedge clk);
    // R8: reset state
    check1("R8", "out_valid after reset", out_valid_o, 1'b0);
    check1("R8", "err after reset", err_o, 1'b0);
    check128("R8", "result after reset", result_o, ZV);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R7", "ready when idle", in_ready_o, 1'b1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [5:0]   ctl;
      logic [127:0] exp;
      logic         exp_err;
      ctl = VEC[i][389:384];
      exp_err = ctl[3] && !ctl[4] && (ctl[1:0] > 2'd1);
      exp = model(ctl[5], ctl[3], ctl[2], ctl[1:0], VEC[i][383:256], VEC[i][255:128], VEC[i][127:0]);
      issue(ctl, VEC[i][383:256], VEC[i][255:128], VEC[i][127:0]);
      check1(tag_of(i), $sformatf("out_valid vec %0d", i), out_valid_o, 1'b1);
      check1(tag_of(i), $sformatf("err vec %0d", i), err_o, exp_err);
      check128(tag_of(i), $sformatf("result vec %0d", i), result_o, exp);
      if (!ctl[5]) check128("R2", $sformatf("upper half vec %0d", i), result_o[127:64], ZV);
    end
    @(negedge clk);
    check1("R7", "valid drops after drain", out_valid_o, 1'b0);

    // R6: out-of-range index keeps the previous result
    issue(6'b100100, ACCS, AMIX, BMIX);
    last = model(1'b1, 1'b0, 1'b1, 2'd0, ACCS, AMIX, BMIX);
    check128("R6", "good result before bad index", result_o, last);
    issue(6'b101110, ZV, BINC, BMIX);
    check1("R6", "bad index err", err_o, 1'b1);
    check1("R6", "bad index valid", out_valid_o, 1'b1);
    check128("R6", "bad index result unchanged", result_o, last);
    issue(6'b001101, ZV, BINC, BMIX);
    check1("R6", "err cleared by good op", err_o, 1'b0);
    check128("R5", "narrow b index 1", result_o, model(1'b0, 1'b1, 1'b1, 2'd1, ZV, BINC, BMIX));

    // R7: stall, then drain and accept in one cycle
    p_res = model(1'b1, 1'b0, 1'b0, 2'd0, ACCS, BINC, AMIX);
    q_res = model(1'b1, 1'b1, 1'b1, 2'd2, AMAX, AMIX, BMIX);
    @(negedge clk);
    out_ready_i = 1'b0;
    drive(6'b100000, ACCS, BINC, AMIX);
    in_valid_i = 1'b1;
    @(negedge clk);
    drive(6'b111110, AMAX, AMIX, BMIX);
    check128("R7", "stalled result P", result_o, p_res);
    check1("R7", "not ready while stalled", in_ready_o, 1'b0);
    repeat (3) @(negedge clk);
    check1("R7", "valid held while stalled", out_valid_o, 1'b1);
    check128("R7", "result held, waiting op not taken", result_o, p_res);
    out_ready_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    check1("R7", "valid after drain plus accept", out_valid_o, 1'b1);
    check128("R7", "new result after drain plus accept", result_o, q_res);
    @(negedge clk);
    check1("R7", "valid drops after final drain", out_valid_o, 1'b0);

    // R3 and R9: unsigned wrap in a narrow form
    issue(6'b000000, ALLF, ALLF, ALLF);
    check128("R9", "narrow unsigned wrap", result_o, {64'h0, 32'h0003F803, 32'h0003F803});

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule